// File: doc/BRIEF.md
# Two-Class Exception Save/Restore Controller

This block decides, once per clock, whether the processor core takes an exception, returns from a handler, or keeps running. Exception sources are split into two classes. Sources 0 to N_CRIT-1 are critical, and the remaining sources up to N_SRC-1 are noncritical.

When an exception is taken, the controller does three things:
- It stores the current program counter and machine-state word in the save pair that belongs to that class.
- It produces a redirect address that points into the handler vector area.
- It produces an updated machine-state word with the relevant enable bits cleared.

Each class also has its own return strobe. A return reloads the program counter and machine state from the matching save pair.

Each class has its own save pair and its own return path. A critical exception can therefore interrupt a running noncritical handler and leave that handler's saved context intact. The core applies `msr_out` when `redir_vld` pulses, and it presents the new state on `msr_in` from then on. All outputs are registered and change one clock edge after the inputs that cause them.

Top module: `xcpt_ctrl`

## Requirements
- R1: After reset, `redir_vld` is 0, and `redir_pc`, `msr_out` and all four save registers are 0.
- R2: A critical entry copies `cur_pc` into `srr_c_pc` and `msr_in` into `srr_c_st`, and leaves `srr_nc_pc` and `srr_nc_st` unchanged. A critical request is taken only when `msr_in` bit 17 is set.
- R3: A noncritical entry copies `cur_pc` into `srr_nc_pc` and `msr_in` into `srr_nc_st`, and leaves the critical pair unchanged. A noncritical request is taken only when `msr_in` bit 15 is set.
- R4: When enabled requests are pending in both classes, the critical one is taken.
- R5: Within a class, the lowest-numbered pending source is taken. The redirect address is `VEC_BASE` (default 0xFFFF0000) OR'd with the source number shifted left by 8.
- R6: A critical entry sets `msr_out` to `msr_in` with bits 17 and 15 cleared. A noncritical entry clears only bit 15. All other bits pass through unchanged.
- R7: While bit 15 of `msr_in` is clear, noncritical requests are ignored. While bit 17 is clear, critical requests are ignored. An ignored request produces no redirect pulse and writes no save register.
- R8: `rfi` loads `redir_pc` from `srr_nc_pc` and `msr_out` from `srr_nc_st`.
- R9: `rfci` loads `redir_pc` from `srr_c_pc` and `msr_out` from `srr_c_st`.
- R10: An enabled exception request takes precedence over a return strobe in the same cycle. When `rfci` and `rfi` arrive together, `rfci` is taken.
- R11: `redir_vld` is high for exactly the one cycle after each entry or return, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_SRC | Exception request lines; low indices are critical |
| cur_pc | input | AW | Address of the current instruction |
| msr_in | input | MW | Current machine-state word |
| rfi | input | 1 | Return from noncritical handler |
| rfci | input | 1 | Return from critical handler |
| redir_pc | output | AW | Fetch redirect address |
| redir_vld | output | 1 | One-cycle pulse qualifying `redir_pc` and `msr_out` |
| msr_out | output | MW | Machine-state word for the core to apply |
| srr_nc_pc | output | AW | Noncritical saved return address |
| srr_nc_st | output | MW | Noncritical saved machine state |
| srr_c_pc | output | AW | Critical saved return address |
| srr_c_st | output | MW | Critical saved machine state |

## Verification
The hardest case to reach is nesting: a critical exception taken while a noncritical handler is running, followed by both returns in order.

The bench first takes a noncritical entry. It then feeds the returned machine state back into `msr_in`, so the noncritical enable bit is clear. With that state applied, it raises a masked noncritical line and a critical line together. It then issues `rfci` followed by `rfi`, feeding back the machine state after each step. Finally it checks that the original program counter and machine state come back unchanged.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_CRIT  = 3'd1,
    ACT_NCRIT = 3'd2,
    ACT_RFCI  = 3'd3,
    ACT_RFI   = 3'd4
  } xcpt_act_e;
endpackage

// File: rtl/xcpt_pick.sv
// Lowest-index-first priority picker.
module xcpt_pick #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    hit = |vec;
  end
endmodule

// File: rtl/xcpt_srr_bank.sv
// One save/restore pair: return address and machine state.
module xcpt_srr_bank #(
  parameter int AW = 32,
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save,
  input  logic [AW-1:0] pc_d,
  input  logic [MW-1:0] st_d,
  output logic [AW-1:0] pc_q,
  output logic [MW-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      st_q <= '0;
    end else if (save) begin
      pc_q <= pc_d;
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/xcpt_ctrl.sv
module xcpt_ctrl
  import xcpt_pkg::*;
#(
  parameter int          N_SRC    = 19,
  parameter int          N_CRIT   = 3,
  parameter int          AW       = 32,
  parameter int          MW       = 32,
  parameter int          NCE_BIT  = 15,
  parameter int          CE_BIT   = 17,
  parameter logic [31:0] VEC_BASE = 32'hFFFF_0000,
  parameter int          SLOT_SH  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  input  logic [AW-1:0]    cur_pc,
  input  logic [MW-1:0]    msr_in,
  input  logic             rfi,
  input  logic             rfci,
  output logic [AW-1:0]    redir_pc,
  output logic             redir_vld,
  output logic [MW-1:0]    msr_out,
  output logic [AW-1:0]    srr_nc_pc,
  output logic [MW-1:0]    srr_nc_st,
  output logic [AW-1:0]    srr_c_pc,
  output logic [MW-1:0]    srr_c_st
);
  localparam int N_NC = N_SRC - N_CRIT;
  localparam int IW   = $clog2(N_SRC);
  localparam int CIW  = (N_CRIT > 1) ? $clog2(N_CRIT) : 1;
  localparam int NIW  = (N_NC > 1) ? $clog2(N_NC) : 1;

  logic [N_CRIT-1:0] c_vec;
  logic [N_NC-1:0]   n_vec;
  logic              c_hit, n_hit;
  logic [CIW-1:0]    c_idx;
  logic [NIW-1:0]    n_idx;

  // Each class is gated by its own enable bit in the machine state.
  assign c_vec = req[N_CRIT-1:0] & {N_CRIT{msr_in[CE_BIT]}};
  assign n_vec = req[N_SRC-1:N_CRIT] & {N_NC{msr_in[NCE_BIT]}};

  xcpt_pick #(.W(N_CRIT), .IW(CIW)) u_pick_c (.vec(c_vec), .hit(c_hit), .idx(c_idx));
  xcpt_pick #(.W(N_NC),   .IW(NIW)) u_pick_n (.vec(n_vec), .hit(n_hit), .idx(n_idx));

  xcpt_act_e       act;
  logic [IW-1:0]   src;
  logic [AW-1:0]   vec_pc;

  always_comb begin
    src = '0;
    if (c_hit) begin
      act = ACT_CRIT;
      src = IW'(c_idx);
    end else if (n_hit) begin
      act = ACT_NCRIT;
      src = IW'(n_idx) + IW'(N_CRIT);
    end else if (rfci) begin
      act = ACT_RFCI;
    end else if (rfi) begin
      act = ACT_RFI;
    end else begin
      act = ACT_NONE;
    end
    vec_pc = AW'(VEC_BASE) | (AW'(src) << SLOT_SH);
  end

  xcpt_srr_bank #(.AW(AW), .MW(MW)) u_bank_nc (
    .clk(clk), .rst(rst), .save(act == ACT_NCRIT),
    .pc_d(cur_pc), .st_d(msr_in), .pc_q(srr_nc_pc), .st_q(srr_nc_st)
  );

  xcpt_srr_bank #(.AW(AW), .MW(MW)) u_bank_c (
    .clk(clk), .rst(rst), .save(act == ACT_CRIT),
    .pc_d(cur_pc), .st_d(msr_in), .pc_q(srr_c_pc), .st_q(srr_c_st)
  );

  logic [MW-1:0] clr_c, clr_n;
  always_comb begin
    clr_n = '0;
    clr_n[NCE_BIT] = 1'b1;
    clr_c = clr_n;
    clr_c[CE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_vld <= 1'b0;
      redir_pc  <= '0;
      msr_out   <= '0;
    end else begin
      redir_vld <= (act != ACT_NONE);
      unique case (act)
        ACT_CRIT: begin
          redir_pc <= vec_pc;
          msr_out  <= msr_in & ~clr_c;
        end
        ACT_NCRIT: begin
          redir_pc <= vec_pc;
          msr_out  <= msr_in & ~clr_n;
        end
        ACT_RFCI: begin
          redir_pc <= srr_c_pc;
          msr_out  <= srr_c_st;
        end
        ACT_RFI: begin
          redir_pc <= srr_nc_pc;
          msr_out  <= srr_nc_st;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xcpt_ctrl_chk.sv
module xcpt_ctrl_chk #(
  parameter int N_SRC   = 19,
  parameter int N_CRIT  = 3,
  parameter int AW      = 32,
  parameter int MW      = 32,
  parameter int NCE_BIT = 15,
  parameter int CE_BIT  = 17
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] req,
  input logic [AW-1:0]    cur_pc,
  input logic [MW-1:0]    msr_in,
  input logic             rfi,
  input logic             rfci,
  input logic [AW-1:0]    redir_pc,
  input logic             redir_vld,
  input logic [MW-1:0]    msr_out,
  input logic [AW-1:0]    srr_nc_pc,
  input logic [MW-1:0]    srr_nc_st,
  input logic [AW-1:0]    srr_c_pc,
  input logic [MW-1:0]    srr_c_st
);
  logic c_go, n_go;
  assign c_go = (|req[N_CRIT-1:0]) && msr_in[CE_BIT];
  assign n_go = (|req[N_SRC-1:N_CRIT]) && msr_in[NCE_BIT];

  // R2, R4: critical entry saves into the critical pair only
  a_r2_crit_save: assert property (@(posedge clk) disable iff (rst)
    c_go |=> redir_vld && srr_c_pc == $past(cur_pc) && srr_c_st == $past(msr_in)
             && $stable(srr_nc_pc) && $stable(srr_nc_st));

  // R3: noncritical entry saves into the noncritical pair only
  a_r3_ncrit_save: assert property (@(posedge clk) disable iff (rst)
    (!c_go && n_go) |=> srr_nc_pc == $past(cur_pc) && srr_nc_st == $past(msr_in)
                        && $stable(srr_c_pc));

  // R6: critical entry clears both enable bits
  a_r6_crit_msr: assert property (@(posedge clk) disable iff (rst)
    c_go |=> !msr_out[CE_BIT] && !msr_out[NCE_BIT]);

  // R9, R10: rfci restores from the critical pair
  a_r9_rfci: assert property (@(posedge clk) disable iff (rst)
    (!c_go && !n_go && rfci) |=> redir_vld && redir_pc == $past(srr_c_pc)
                                 && msr_out == $past(srr_c_st));

  // R8: rfi restores from the noncritical pair
  a_r8_rfi: assert property (@(posedge clk) disable iff (rst)
    (!c_go && !n_go && !rfci && rfi) |=> redir_pc == $past(srr_nc_pc)
                                         && msr_out == $past(srr_nc_st));

  // R7, R11: nothing enabled, no redirect
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    (!c_go && !n_go && !rfci && !rfi) |=> !redir_vld && $stable(srr_nc_pc)
                                          && $stable(srr_c_pc));
endmodule

bind xcpt_ctrl xcpt_ctrl_chk #(
  .N_SRC(N_SRC), .N_CRIT(N_CRIT), .AW(AW), .MW(MW),
  .NCE_BIT(NCE_BIT), .CE_BIT(CE_BIT)
) chk_i (
  .clk(clk), .rst(rst), .req(req), .cur_pc(cur_pc), .msr_in(msr_in),
  .rfi(rfi), .rfci(rfci), .redir_pc(redir_pc), .redir_vld(redir_vld),
  .msr_out(msr_out), .srr_nc_pc(srr_nc_pc), .srr_nc_st(srr_nc_st),
  .srr_c_pc(srr_c_pc), .srr_c_st(srr_c_st)
);

// File: tb/xcpt_ctrl_tb_top.sv
`timescale 1ns/1ps
module xcpt_ctrl_tb_top;
  localparam logic [31:0] NCE  = 32'h0000_8000;
  localparam logic [31:0] CE   = 32'h0002_0000;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [18:0] req;
  logic [31:0] cur_pc, msr_in;
  logic        rfi, rfci;
  logic [31:0] redir_pc, msr_out, srr_nc_pc, srr_nc_st, srr_c_pc, srr_c_st;
  logic        redir_vld;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  xcpt_ctrl dut_i (
    .clk(clk), .rst(rst), .req(req), .cur_pc(cur_pc), .msr_in(msr_in),
    .rfi(rfi), .rfci(rfci), .redir_pc(redir_pc), .redir_vld(redir_vld),
    .msr_out(msr_out), .srr_nc_pc(srr_nc_pc), .srr_nc_st(srr_nc_st),
    .srr_c_pc(srr_c_pc), .srr_c_st(srr_c_st)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec(input int s);
    return BASE | (32'(s) << 8);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req = '0; rfi = 0; rfci = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle(); cur_pc = 0; msr_in = 0;
    step(); step();
    chk("R1 vld", 32'(redir_vld), 0);
    chk("R1 pc", redir_pc, 0);
    chk("R1 msr", msr_out, 0);
    chk("R1 srr0", srr_nc_pc, 0);
    chk("R1 srr1", srr_nc_st, 0);
    chk("R1 srr2", srr_c_pc, 0);
    chk("R1 srr3", srr_c_st, 0);
    rst = 0; step();
  endtask

  task automatic t_crit();
    logic [31:0] m;
    m = 32'h0002_8123;
    cur_pc = 32'h0000_4000; msr_in = m; req = 19'b110;
    step();
    chk("R2 vld", 32'(redir_vld), 1);
    chk("R2 srr2", srr_c_pc, 32'h4000);
    chk("R2 srr3", srr_c_st, m);
    chk("R2 srr0 kept", srr_nc_pc, 0);
    chk("R5 crit vec", redir_pc, vec(1));
    chk("R6 crit msr", msr_out, m & ~(CE | NCE));
    idle(); step();
    chk("R11 pulse", 32'(redir_vld), 0);
  endtask

  task automatic t_ncrit();
    logic [31:0] m;
    m = 32'h0002_8055;
    cur_pc = 32'h0000_5000; msr_in = m; req = 19'h0;
    req[18] = 1; req[9] = 1;
    step();
    chk("R3 srr0", srr_nc_pc, 32'h5000);
    chk("R3 srr1", srr_nc_st, m);
    chk("R3 srr2 kept", srr_c_pc, 32'h4000);
    chk("R5 nc vec", redir_pc, vec(9));
    chk("R6 nc msr", msr_out, m & ~NCE);
    idle(); step();
  endtask

  task automatic t_prio();
    cur_pc = 32'h0000_6000; msr_in = CE | NCE; req = '0;
    req[3] = 1; req[2] = 1;
    step();
    chk("R4 crit wins pc", redir_pc, vec(2));
    chk("R4 srr2", srr_c_pc, 32'h6000);
    chk("R4 srr0 kept", srr_nc_pc, 32'h5000);
    idle(); step();
  endtask

  task automatic t_mask();
    cur_pc = 32'h0000_7000; msr_in = CE; req = '0; req[4] = 1;
    step();
    chk("R7 nc masked vld", 32'(redir_vld), 0);
    chk("R7 nc masked srr0", srr_nc_pc, 32'h5000);
    msr_in = NCE; req = 19'b001;
    step();
    chk("R7 crit masked vld", 32'(redir_vld), 0);
    chk("R7 crit masked srr2", srr_c_pc, 32'h6000);
    idle(); step();
  endtask

  task automatic t_nested();
    logic [31:0] m0, m1, m2;
    m0 = 32'h0002_8A5A; m1 = m0 & ~NCE; m2 = m0 & ~(CE | NCE);
    cur_pc = 32'h0000_1000; msr_in = m0; req = '0; req[7] = 1;
    step();
    chk("R3 nest entry pc", redir_pc, vec(7));
    chk("R6 nest entry msr", msr_out, m1);
    msr_in = msr_out; cur_pc = 32'hFFFF_0710; req = '0; req[5] = 1; req[1] = 1;
    step();
    chk("R2 nest crit pc", redir_pc, vec(1));
    chk("R2 nest srr3", srr_c_st, m1);
    chk("R2 nest srr0 kept", srr_nc_pc, 32'h1000);
    chk("R2 nest srr1 kept", srr_nc_st, m0);
    msr_in = msr_out; idle(); req[5] = 1; rfci = 1;
    step();
    chk("R9 rfci pc", redir_pc, 32'hFFFF_0710);
    chk("R9 rfci msr", msr_out, m1);
    chk("R7 masked under m2", msr_in, m2);
    msr_in = msr_out; idle(); rfi = 1;
    step();
    chk("R8 rfi pc", redir_pc, 32'h1000);
    chk("R8 rfi msr", msr_out, m0);
    idle(); step();
  endtask

  task automatic t_collide();
    cur_pc = 32'h0000_8000; msr_in = CE | NCE; idle(); req[12] = 1; rfi = 1;
    step();
    chk("R10 exc over rfi pc", redir_pc, vec(12));
    chk("R10 srr0 written", srr_nc_pc, 32'h8000);
    idle(); rfi = 1; rfci = 1;
    step();
    chk("R10 rfci over rfi", redir_pc, srr_c_pc);
    chk("R11 vld on return", 32'(redir_vld), 1);
    idle(); step();
    chk("R11 idle", 32'(redir_vld), 0);
  endtask

  initial begin
    t_reset();
    t_crit();
    t_ncrit();
    t_prio();
    t_mask();
    t_nested();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule